// File: doc/BRIEF.md
# ALU Dependency Delay Tracker

This block sits at the in-order issue point of one hardware thread and carries out a delay hint that the compiler places in the instruction stream. A hint names up to two later instructions. For each of them it names the earlier producer that instruction must wait for. That producer is a recent vector ALU instruction, a recent transcendental instruction, the FMA accumulation path, or a scalar ALU result that needs some cycles to settle. The block does no hazard detection of its own. It only obeys the hint.

The block sees three inputs. The first is the decoded 11-bit hint word. The second is the instruction offered for issue, tagged with its unit class. The third is the completion pulses from the vector and transcendental units. While the offered instruction is one that the current hint targets and its named producer has not finished, the block raises `stall`. An instruction is issued on a clock edge where `issue_valid` is high and `stall` is low. The hint instruction is a no-op and never arrives in the same cycle as an issued instruction.

A small state machine holds the hint and has three states:
- `ST_IDLE`: no hint is armed.
- `ST_FIRST`: waiting for the first instruction after the hint.
- `ST_SECOND`: counting toward the second target.

Its transitions are:
- load: any state goes to `ST_FIRST` on a hint with a live slot, or to `ST_IDLE` on an all-empty hint.
- first issue: `ST_FIRST` goes to `ST_SECOND` when a second target lies further on, otherwise to `ST_IDLE`.
- count: `ST_SECOND` stays in `ST_SECOND` while the position is short of the skip distance.
- release: `ST_SECOND` goes to `ST_IDLE` when the second target issues.

Top module: `alu_dep_delay`

## Requirements
- R1: The hint word holds the first-slot code in bits 3:0, the skip code in bits 6:4 and the second-slot code in bits 10:7. A hint is loaded in the cycle `hint_valid` is high.
- R2: Slot code 0 means no dependency. Slot codes 12 to 15 are treated as code 0. Skip codes 6 and 7 void the second slot. A void slot never raises `stall`.
- R3: Slot codes 1 to 4 (vector ALU, N = code back) stall the targeted instruction while at least N vector ALU instructions remain outstanding. Completions retire them oldest first.
- R4: Slot codes 5 to 7 (transcendental, N = code - 4 back) stall the target while at least N transcendental instructions remain outstanding.
- R5: Slot code 8 (FMA accumulate) stalls the target only in the cycle directly after a vector ALU issue.
- R6: Slot codes 9 to 11 (scalar ALU, N = code - 8 cycles) stall the target for the first N cycles after the most recent scalar ALU issue.
- R7: The first slot targets the first instruction issued after the hint. The second slot targets the instruction at distance D from it, where skip code D is 0 for the same instruction, 1 for the next one, and 2 to 5 for skipping 1 to 4 instructions.
- R8: The hint instruction does not count toward the skip distance. Every issued instruction counts, whatever its class (0 other, 1 vector ALU, 2 transcendental, 3 scalar ALU).
- R9: A new hint replaces a hint whose targets have not all been issued.
- R10: `stall` is low after reset, low while `issue_valid` is low, and low when no hint target is being offered. A completion pulse affects `stall` from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hint_valid | input | 1 | Delay hint presented this cycle |
| hint_word | input | 11 | Encoded hint: first code, skip, second code |
| issue_valid | input | 1 | An instruction is offered for issue |
| issue_class | input | 2 | Unit class of the offered instruction |
| valu_done | input | 1 | Oldest outstanding vector ALU instruction completed |
| trans_done | input | 1 | Oldest outstanding transcendental instruction completed |
| stall | output | 1 | Hold back the offered instruction |

## Verification
Two functions can fall in the same cycle. In the first, both hint slots can land on the same instruction, when the skip code is "same". In the second, one producer class can retire a completion in the same cycle that a new producer of that class issues. The sweep covers every first-slot code against every skip code and a spread of second-slot codes. Its post-hint stream mixes unit classes with completion pulses, so both collisions happen many times. Each cycle's `stall` is judged against an arithmetic model. That model combines both slots' conditions and applies completion and issue to the counts on the same edge.

// File: rtl/alu_dep_pkg.sv
package alu_dep_pkg;

    typedef enum logic [1:0] {
        CLS_OTHER = 2'd0,
        CLS_VALU  = 2'd1,
        CLS_TRANS = 2'd2,
        CLS_SALU  = 2'd3
    } unit_cls_e;

    localparam int ID_W   = 4;
    localparam int SKIP_W = 3;
    localparam int HINT_W = 2 * ID_W + SKIP_W;

    localparam logic [ID_W-1:0]   ID_NONE   = 4'd0;
    localparam logic [ID_W-1:0]   ID_LAST   = 4'd11;
    localparam logic [SKIP_W-1:0] SKIP_LAST = 3'd5;

    // Reserved slot codes collapse to "no dependency".
    function automatic logic [ID_W-1:0] clean_id(input logic [ID_W-1:0] code);
        return (code > ID_LAST) ? ID_NONE : code;
    endfunction

endpackage

// File: rtl/alu_dep_track.sv
module alu_dep_track #(
    parameter int CNT_W    = 3,
    parameter int SALU_CYC = 3,
    parameter int SW_W     = $clog2(SALU_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valu,
    input  logic             acc_trans,
    input  logic             acc_salu,
    input  logic             valu_done,
    input  logic             trans_done,
    output logic [CNT_W-1:0] valu_cnt,
    output logic [CNT_W-1:0] trans_cnt,
    output logic [SW_W-1:0]  salu_wait,
    output logic             fma_busy
);
    localparam int NCLS = 2;

    logic [NCLS-1:0] inc_v;
    logic [NCLS-1:0] dec_v;

    assign inc_v = {acc_trans, acc_valu};
    assign dec_v = {trans_done, valu_done};

    // One in-order outstanding counter per tracked unit class.
    for (genvar g = 0; g < NCLS; g++) begin : g_cls
        logic [CNT_W-1:0] cnt_q;
        logic [CNT_W-1:0] after_dec;

        always_comb begin
            after_dec = cnt_q;
            if (dec_v[g] && (cnt_q != '0)) after_dec = cnt_q - 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            cnt_q <= '0;
            else if (inc_v[g] && (after_dec != '1)) cnt_q <= after_dec + 1'b1;
            else                                   cnt_q <= after_dec;
        end
    end

    assign valu_cnt  = g_cls[0].cnt_q;
    assign trans_cnt = g_cls[1].cnt_q;

    logic [SW_W-1:0] sw_q;
    logic            fma_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q  <= '0;
            fma_q <= 1'b0;
        end else begin
            fma_q <= acc_valu;
            if (acc_salu)          sw_q <= SW_W'(SALU_CYC);
            else if (sw_q != '0)   sw_q <= sw_q - 1'b1;
        end
    end

    assign salu_wait = sw_q;
    assign fma_busy  = fma_q;

endmodule

// File: rtl/alu_dep_hint_fsm.sv
module alu_dep_hint_fsm
    import alu_dep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hint_valid,
    input  logic [HINT_W-1:0] hint_word,
    input  logic              issue_acc,
    output logic [ID_W-1:0]   act_a,
    output logic [ID_W-1:0]   act_b,
    output logic              fsm_idle,
    output logic [SKIP_W-1:0] fsm_pos
);
    typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND} st_e;

    st_e               st_q, st_d;
    logic [ID_W-1:0]   ida_q, ida_d, idb_q, idb_d;
    logic [SKIP_W-1:0] dist_q, dist_d, pos_q, pos_d;
    logic [ID_W-1:0]   new_a, new_b;
    logic [SKIP_W-1:0] new_skip;

    always_comb begin
        new_a    = clean_id(hint_word[ID_W-1:0]);
        new_skip = hint_word[ID_W+SKIP_W-1:ID_W];
        new_b    = (new_skip > SKIP_LAST) ? ID_NONE
                                          : clean_id(hint_word[HINT_W-1:ID_W+SKIP_W]);
    end

    // Next state
    always_comb begin
        st_d   = st_q;
        ida_d  = ida_q;
        idb_d  = idb_q;
        dist_d = dist_q;
        pos_d  = pos_q;
        if (hint_valid) begin
            ida_d  = new_a;
            idb_d  = new_b;
            dist_d = new_skip;
            pos_d  = '0;
            st_d   = ((new_a != ID_NONE) || (new_b != ID_NONE)) ? ST_FIRST : ST_IDLE;
        end else if (issue_acc) begin
            unique case (st_q)
                ST_IDLE: st_d = ST_IDLE;
                ST_FIRST: begin
                    if ((idb_q != ID_NONE) && (dist_q != '0)) begin
                        st_d  = ST_SECOND;
                        pos_d = SKIP_W'(1);
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
                ST_SECOND: begin
                    if (pos_q == dist_q) st_d  = ST_IDLE;
                    else                 pos_d = pos_q + 1'b1;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ida_q  <= ID_NONE;
            idb_q  <= ID_NONE;
            dist_q <= '0;
            pos_q  <= '0;
        end else begin
            st_q   <= st_d;
            ida_q  <= ida_d;
            idb_q  <= idb_d;
            dist_q <= dist_d;
            pos_q  <= pos_d;
        end
    end

    // Outputs: dependency codes applying to the instruction now offered
    always_comb begin
        act_a = ID_NONE;
        act_b = ID_NONE;
        unique case (st_q)
            ST_FIRST: begin
                act_a = ida_q;
                if (dist_q == '0) act_b = idb_q;
            end
            ST_SECOND: begin
                if (pos_q == dist_q) act_b = idb_q;
            end
            default: begin
                act_a = ID_NONE;
                act_b = ID_NONE;
            end
        endcase
        fsm_idle = (st_q == ST_IDLE);
        fsm_pos  = pos_q;
    end

endmodule

// File: rtl/alu_dep_delay.sv
module alu_dep_delay
    import alu_dep_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hint_valid,
    input  logic [10:0] hint_word,
    input  logic        issue_valid,
    input  logic [1:0]  issue_class,
    input  logic        valu_done,
    input  logic        trans_done,
    output logic        stall
);
    localparam int SALU_CYC = 3;
    localparam int SW_W     = $clog2(SALU_CYC + 1);

    logic              issue_acc;
    logic [ID_W-1:0]   act_a, act_b;
    logic              fsm_idle;
    logic [SKIP_W-1:0] fsm_pos;
    logic [CNT_W-1:0]  valu_cnt, trans_cnt;
    logic [SW_W-1:0]   salu_wait;
    logic              fma_busy;
    unit_cls_e         cls;

    function automatic logic dep_blocked(input logic [ID_W-1:0]  code,
                                         input logic [CNT_W-1:0] vc,
                                         input logic [CNT_W-1:0] tc,
                                         input logic [SW_W-1:0]  sw,
                                         input logic             fb);
        int n;
        n = int'(code);
        if (n >= 1 && n <= 4)       return int'(vc) >= n;
        else if (n >= 5 && n <= 7)  return int'(tc) >= n - 4;
        else if (n == 8)            return fb;
        else if (n >= 9 && n <= 11) return int'(sw) >= 12 - n;
        return 1'b0;
    endfunction

    assign cls       = unit_cls_e'(issue_class);
    assign stall     = issue_valid &&
                       (dep_blocked(act_a, valu_cnt, trans_cnt, salu_wait, fma_busy) ||
                        dep_blocked(act_b, valu_cnt, trans_cnt, salu_wait, fma_busy));
    assign issue_acc = issue_valid && !stall;

    alu_dep_hint_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hint_valid (hint_valid),
        .hint_word  (hint_word),
        .issue_acc  (issue_acc),
        .act_a      (act_a),
        .act_b      (act_b),
        .fsm_idle   (fsm_idle),
        .fsm_pos    (fsm_pos)
    );

    alu_dep_track #(
        .CNT_W    (CNT_W),
        .SALU_CYC (SALU_CYC),
        .SW_W     (SW_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valu   (issue_acc && (cls == CLS_VALU)),
        .acc_trans  (issue_acc && (cls == CLS_TRANS)),
        .acc_salu   (issue_acc && (cls == CLS_SALU)),
        .valu_done  (valu_done),
        .trans_done (trans_done),
        .valu_cnt   (valu_cnt),
        .trans_cnt  (trans_cnt),
        .salu_wait  (salu_wait),
        .fma_busy   (fma_busy)
    );

endmodule

// File: rtl/alu_dep_delay_chk.sv
module alu_dep_delay_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        hint_valid,
    input logic [10:0] hint_word,
    input logic        issue_valid,
    input logic [1:0]  issue_class,
    input logic        trans_done,
    input logic        stall,
    input logic        fsm_idle,
    input logic [2:0]  trans_cnt,
    input logic [2:0]  pos
);
    // R10: stall only while an instruction is offered
    a_r10_stall_needs_issue: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> issue_valid);

    // R10: no armed target, no stall
    a_r10_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_idle |-> !stall);

    // R2: an all-empty hint leaves the next cycle free of stalls
    a_r2_null_hint_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (hint_valid && hint_word == 11'd0) |=> !stall);

    // R9: a hint with a live first slot restarts the count from its first target
    a_r9_hint_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (hint_valid && hint_word[3:0] >= 4'd1 && hint_word[3:0] <= 4'd11)
        |=> (!fsm_idle && pos == 3'd0));

    // R4: the last outstanding transcendental retires on its completion pulse
    a_r4_trans_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (trans_cnt == 3'd1 && trans_done && !(issue_valid && issue_class == 2'd2))
        |=> trans_cnt == 3'd0);

endmodule

bind alu_dep_delay alu_dep_delay_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hint_valid  (hint_valid),
    .hint_word   (hint_word),
    .issue_valid (issue_valid),
    .issue_class (issue_class),
    .trans_done  (trans_done),
    .stall       (stall),
    .fsm_idle    (fsm_idle),
    .trans_cnt   (trans_cnt),
    .pos         (fsm_pos)
);

// File: tb/alu_dep_delay_bench.sv
`timescale 1ns/1ps
module alu_dep_delay_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        hint_valid;
    logic [10:0] hint_word;
    logic        issue_valid;
    logic [1:0]  issue_class;
    logic        valu_done;
    logic        trans_done;
    logic        stall;

    always #2.5 clk = ~clk;

    alu_dep_delay u_alu_dep_delay (
        .clk         (clk),
        .rst_n       (rst_n),
        .hint_valid  (hint_valid),
        .hint_word   (hint_word),
        .issue_valid (issue_valid),
        .issue_class (issue_class),
        .valu_done   (valu_done),
        .trans_done  (trans_done),
        .stall       (stall)
    );

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done_flag = 0;

    // Reference model state
    int mv = 0, mt = 0, msw = 0;
    bit mfma = 0;
    bit mpend = 0;
    int mpos = 0, mA = 0, mB = 0, mdist = 0;

    function automatic int fix_code(int c);
        return (c > 11) ? 0 : c;
    endfunction

    function automatic bit mblk(int id);
        if (id >= 1 && id <= 4) return mv >= id;
        if (id >= 5 && id <= 7) return mt >= id - 4;
        if (id == 8) return mfma;
        if (id >= 9 && id <= 11) return msw > 11 - id;
        return 0;
    endfunction

    function automatic string tag_of(int id);
        if (id >= 1 && id <= 4) return "R7/R3";
        if (id >= 5 && id <= 7) return "R7/R4";
        if (id == 8) return "R7/R5";
        if (id >= 9) return "R7/R6";
        return "R7/R2";
    endfunction

    task automatic check(bit got, bit exp, string rq);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: stall=%0b expected %0b (t=%0t)", rq, got, exp, $time);
        end
    endtask

    task automatic cyc(bit iv, int cls, bit vd, bit td, bit hv, int hw, string rq);
        int a, b, sk;
        bit exp, acc;
        string t;
        @(negedge clk);
        issue_valid = iv;
        issue_class = 2'(cls);
        valu_done   = vd;
        trans_done  = td;
        hint_valid  = hv;
        hint_word   = 11'(hw);
        #1;
        a = (mpend && mpos == 0) ? mA : 0;
        b = (mpend && mpos == mdist) ? mB : 0;
        exp = iv && (mblk(a) || mblk(b));
        t = rq;
        if (t == "") t = mblk(b) ? tag_of(b) : tag_of(a);
        check(stall, exp, t);
        acc = iv && !exp;
        mv = mv - ((vd && mv > 0) ? 1 : 0) + ((acc && cls == 1) ? 1 : 0);
        if (mv > 7) mv = 7;
        mt = mt - ((td && mt > 0) ? 1 : 0) + ((acc && cls == 2) ? 1 : 0);
        if (mt > 7) mt = 7;
        if (acc && cls == 3) msw = 3;
        else if (msw > 0) msw = msw - 1;
        mfma = acc && cls == 1;
        if (hv) begin
            mA = fix_code(hw & 15);
            sk = (hw >> 4) & 7;
            mB = (sk > 5) ? 0 : fix_code((hw >> 7) & 15);
            mdist = sk;
            mpos = 0;
            mpend = (mA != 0) || (mB != 0);
        end else if (acc && mpend) begin
            mpos = mpos + 1;
            mpend = (mB != 0) && (mpos <= mdist);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done_flag) begin
            done_flag = 1;
            total++;
            bad++;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        hint_valid = 0; hint_word = 0; issue_valid = 1; issue_class = 0;
        valu_done = 0; trans_done = 0;
        #1;
        check(stall, 1'b0, "R10 in reset");
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(stall, 1'b0, "R10 after reset");

        // R8: hint not counted; second slot targets the next instruction
        cyc(1, 1, 0, 0, 0, 0, "R8 producer");
        cyc(0, 0, 0, 0, 1, (1 << 7) | (1 << 4), "R1");
        cyc(1, 0, 0, 0, 0, 0, "R8 first target free");
        cyc(1, 0, 1, 0, 0, 0, "R8 second target held");
        cyc(1, 0, 0, 0, 0, 0, "R10 release after completion");

        // R9: replacement by an empty hint
        repeat (4) cyc(1, 1, 0, 0, 0, 0, "R9 producer");
        cyc(0, 0, 0, 0, 1, 4, "R1");
        cyc(0, 0, 0, 0, 1, 0, "R9");
        cyc(1, 0, 0, 0, 0, 0, "R9 replaced hint");
        repeat (8) cyc(0, 0, 1, 1, 0, 0, "R10 drain");

        // Near-exhaustive sweep over first code, skip code and second codes
        for (int a = 0; a < 16; a++) begin
            for (int sk = 0; sk < 8; sk++) begin
                for (int bi = 0; bi < 6; bi++) begin
                    int bcode;
                    case (bi)
                        0: bcode = 0;
                        1: bcode = 2;
                        2: bcode = 6;
                        3: bcode = 8;
                        4: bcode = 10;
                        default: bcode = 15;
                    endcase
                    repeat (9) cyc(0, 0, 1, 1, 0, 0, "R10 drain");
                    repeat ((a + sk) % 4 + 1) cyc(1, 1, 0, 0, 0, 0, "");
                    repeat ((a + bi) % 3 + 1) cyc(1, 2, 0, 0, 0, 0, "");
                    cyc(1, 3, 0, 0, 0, 0, "");
                    cyc(0, 0, 0, 0, 1, (bcode << 7) | (sk << 4) | a, "R1");
                    for (int k = 0; k < 12; k++) begin
                        cyc((k % 5) != 4, (k * (bi + 1) + a) % 4,
                            ((k + a) % 3) == 0, ((k + sk) % 4) == 1, 0, 0, "");
                    end
                end
            end
        end

        if (!done_flag) begin
            done_flag = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule